// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns the prefix word of a vectorised instruction into a per-element enable mask. It checks that the prefix is a vector prefix and extracts a 4-bit mask selector from it. It then builds one enable bit per element from one of three sources:

- one of three integer registers, taken as is or inverted;
- one flag taken from a run of 4-bit condition fields;
- a constant that enables every element.

Elements at or past the vector length are always disabled. The one reserved selector code is reported as an illegal instruction.

The issue stage uses it as follows. It presents the prefix, the three candidate integer register values, the whole condition-field file and the vector length, together with a one-cycle valid strobe. One clock later the block returns the registered mask, the illegal flag and a matching valid strobe. Bit numbering inside the prefix is most-significant-first: prefix bit n is port bit `prefix[31-n]`.

Top module: `pred_mask_gen`

## Requirements
- R1: A prefix qualifies only when bits 0:5 (`prefix[31:26]`) equal 1 and bits 7 and 9 (`prefix[24]`, `prefix[22]`) are both 1. A non-qualifying prefix yields an all-zero mask with the illegal flag low.
- R2: The selector is {bit 6, bit 8, bit 10, bit 11} of the prefix, that is {`prefix[25]`, `prefix[23]`, `prefix[21]`, `prefix[20]`}, with the first listed bit as selector MSB. No other prefix bit changes the outputs of a qualifying prefix.
- R3: Selector 0000 raises the illegal flag and forces the mask to all zeros.
- R4: Selector 0001 enables every element below the vector length.
- R5: Selectors 0010, 0100 and 0110 enable element i when bit i (LSB = element 0) of `gpr_a`, `gpr_b` or `gpr_c`, respectively, is 1.
- R6: Selectors 0011, 0101 and 0111 use the same registers as R5 but enable element i when that bit is 0.
- R7: Selectors 1xxx test one flag of condition field k, held in `cr_file[4k+3:4k]`, with flag order LT=bit 3, GT=bit 2, EQ=bit 1, SO=bit 0. Selector bits [2:1] pick the flag (00 LT, 01 GT, 10 EQ, 11 SO). Selector bit 0 = 0 enables when the flag is 1, and 1 enables when it is 0.
- R8: Element i reads condition field (6+i) mod 64, so element 57 reads field 63 and element 58 reads field 0.
- R9: Element i is forced to 0 when i >= `vec_len`. Lengths 0 to 64 are valid: 0 gives an empty mask and 64 leaves all elements open.
- R10: `out_valid`, `out_mask` and `out_illegal` change one clock edge after an edge with `in_valid` high. `out_valid` is a one-cycle strobe. The mask and flag hold their value while `in_valid` is low.
- R11: A synchronous active-low reset clears `out_valid`, `out_mask` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs are valid this cycle |
| prefix | input | 32 | Instruction prefix word |
| gpr_a | input | 64 | Integer predicate candidate for selectors 001x |
| gpr_b | input | 64 | Integer predicate candidate for selectors 010x |
| gpr_c | input | 64 | Integer predicate candidate for selectors 011x |
| cr_file | input | 256 | 64 condition fields, field k at bits 4k+3:4k |
| vec_len | input | 7 | Vector length, 0 to 64 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_mask | output | 64 | Element enable mask, bit i = element i |
| out_illegal | output | 1 | Reserved selector seen on a qualifying prefix |

## Verification
The bench targets the following corner cases:

- **Condition-field wrap.** A field index that does not wrap would light element 58 from field 64 instead of field 0, or would lose the top elements.
- **Vector length 0 and 64.** An off-by-one length comparison would leak or drop element 0 or element 63.
- **Reserved selector against the all-enable selector.** Confusing the two would yield either a full mask with no trap or a trap on a legal code.
- **Prefix qualification bits and selector bit positions.** Swapping a scattered selector bit would pick the wrong register or flag. A missing qualification term would let an ordinary prefix generate a mask.
- **Inversion codes and flag ordering.** Reversing the flag order would cross LT with SO and GT with EQ. Dropping the odd-code inversion would return the direct mask.

// File: rtl/pm_pkg.sv
// Package: shared parameters and types for the predicate mask generator.
// Assumes 4-bit condition fields and a 4-bit mask selector.
package pm_pkg;

    localparam int SEL_W  = 4;
    localparam int CRF_W  = 4;

    // Source of the per-element enable bits.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ALL  = 2'd1,
        SRC_GPR  = 2'd2,
        SRC_CR   = 2'd3
    } src_kind_e;

    // Decoded view of the prefix.
    typedef struct packed {
        logic      is_vec;
        logic      illegal;
        src_kind_e kind;
        logic [1:0] gpr_pick;
        logic [1:0] flag_pick;
        logic      invert;
    } sel_info_t;

endpackage

// File: rtl/pm_prefix_decode.sv
// Prefix decoder: checks the vector-prefix qualification bits and turns the
// scattered selector bits into a source kind, register pick, flag pick and
// invert bit. Pure combinational. Assumes MSB-first bit numbering of the prefix.
module pm_prefix_decode
    import pm_pkg::*;
#(
    parameter int PFX_W = 32
) (
    input  logic [PFX_W-1:0] prefix,
    output sel_info_t        info
);
    // MSB-first bit n sits at port index PFX_W-1-n.
    localparam int B_OP_HI = PFX_W - 1;
    localparam int B_OP_LO = PFX_W - 6;
    localparam int B_RM0   = PFX_W - 1 - 6;
    localparam int B_TAG7  = PFX_W - 1 - 7;
    localparam int B_RM1   = PFX_W - 1 - 8;
    localparam int B_TAG9  = PFX_W - 1 - 9;
    localparam int B_RM2   = PFX_W - 1 - 10;
    localparam int B_RM3   = PFX_W - 1 - 11;

    logic [SEL_W-1:0] sel;
    logic             qualifies;
    logic             unused_rest;

    // Gather the selector bits (R2) and the qualification test (R1).
    always_comb begin
        sel       = {prefix[B_RM0], prefix[B_RM1], prefix[B_RM2], prefix[B_RM3]};
        qualifies = (prefix[B_OP_HI:B_OP_LO] == 6'd1) && prefix[B_TAG7] && prefix[B_TAG9];
    end

    assign unused_rest = ^prefix[B_RM3-1:0];

    // Map the selector onto a source description.
    always_comb begin
        info           = '0;
        info.is_vec    = qualifies;
        info.invert    = sel[0];
        info.gpr_pick  = sel[2:1];
        info.flag_pick = sel[2:1];
        info.kind      = SRC_NONE;
        if (qualifies) begin
            if (sel[3]) begin
                info.kind = SRC_CR;
            end else if (sel[2:1] != 2'b00) begin
                info.kind = SRC_GPR;
            end else if (sel[0]) begin
                info.kind = SRC_ALL;
            end else begin
                info.illegal = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pm_gpr_select.sv
// Integer predicate source: chooses one of three registers by a 2-bit pick
// (01, 10, 11) and optionally inverts it. Pick 00 yields zeros; it is never
// selected by the decoder for this source.
module pm_gpr_select #(
    parameter int ELEMS = 64
) (
    input  logic [ELEMS-1:0] gpr_a,
    input  logic [ELEMS-1:0] gpr_b,
    input  logic [ELEMS-1:0] gpr_c,
    input  logic [1:0]       pick,
    input  logic             invert,
    output logic [ELEMS-1:0] bits
);
    logic [ELEMS-1:0] chosen;

    // Register mux.
    always_comb begin
        case (pick)
            2'b01:   chosen = gpr_a;
            2'b10:   chosen = gpr_b;
            2'b11:   chosen = gpr_c;
            default: chosen = '0;
        endcase
    end

    // Apply the optional inversion.
    assign bits = invert ? ~chosen : chosen;
endmodule

// File: rtl/pm_cr_gather.sv
// Condition-field predicate source: element i reads one flag of field
// (BASE+i) mod NUM_CR. Flags in a field run LT, GT, EQ, SO from the MSB down,
// so flag pick p selects field bit (3-p). Assumes 4-bit fields.
module pm_cr_gather
    import pm_pkg::*;
#(
    parameter int ELEMS  = 64,
    parameter int NUM_CR = 64,
    parameter int BASE   = 6
) (
    input  logic [NUM_CR*CRF_W-1:0] cr_file,
    input  logic [1:0]              flag_pick,
    input  logic                    invert,
    output logic [ELEMS-1:0]        bits
);
    genvar i;
    generate
        for (i = 0; i < ELEMS; i++) begin : g_elem
            localparam int FIELD = (BASE + i) % NUM_CR;
            logic [CRF_W-1:0] fld;
            // Pick the field of this element and test the chosen flag.
            always_comb begin
                fld     = cr_file[FIELD*CRF_W +: CRF_W];
                bits[i] = fld[~flag_pick] ^ invert;
            end
        end
    endgenerate
endmodule

// File: rtl/pm_len_limit.sv
// Length limiter: bit i of the output is 1 when i < vec_len. Lengths above
// ELEMS behave as ELEMS.
module pm_len_limit #(
    parameter int ELEMS = 64,
    parameter int LEN_W = 7
) (
    input  logic [LEN_W-1:0] vec_len,
    output logic [ELEMS-1:0] open
);
    genvar i;
    generate
        for (i = 0; i < ELEMS; i++) begin : g_lim
            // Element is inside the vector.
            assign open[i] = (vec_len > LEN_W'(i));
        end
    endgenerate
endmodule

// File: rtl/pred_mask_gen.sv
// Top: builds the registered per-element predicate mask from the prefix,
// three integer predicate candidates, the condition-field file and the
// vector length. One cycle of latency; synchronous active-low reset.
module pred_mask_gen
    import pm_pkg::*;
#(
    parameter int PFX_W  = 32,
    parameter int ELEMS  = 64,
    parameter int NUM_CR = 64,
    parameter int CR_BASE = 6,
    localparam int LEN_W = $clog2(ELEMS + 1),
    localparam int CR_W  = NUM_CR * CRF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PFX_W-1:0] prefix,
    input  logic [ELEMS-1:0] gpr_a,
    input  logic [ELEMS-1:0] gpr_b,
    input  logic [ELEMS-1:0] gpr_c,
    input  logic [CR_W-1:0]  cr_file,
    input  logic [LEN_W-1:0] vec_len,
    output logic             out_valid,
    output logic [ELEMS-1:0] out_mask,
    output logic             out_illegal
);
    sel_info_t        info;
    logic [ELEMS-1:0] gpr_bits;
    logic [ELEMS-1:0] cr_bits;
    logic [ELEMS-1:0] len_open;
    logic [ELEMS-1:0] raw_mask;
    logic [ELEMS-1:0] next_mask;

    pm_prefix_decode #(.PFX_W(PFX_W)) i_dec (
        .prefix (prefix),
        .info   (info)
    );

    pm_gpr_select #(.ELEMS(ELEMS)) i_gpr (
        .gpr_a  (gpr_a),
        .gpr_b  (gpr_b),
        .gpr_c  (gpr_c),
        .pick   (info.gpr_pick),
        .invert (info.invert),
        .bits   (gpr_bits)
    );

    pm_cr_gather #(.ELEMS(ELEMS), .NUM_CR(NUM_CR), .BASE(CR_BASE)) i_cr (
        .cr_file   (cr_file),
        .flag_pick (info.flag_pick),
        .invert    (info.invert),
        .bits      (cr_bits)
    );

    pm_len_limit #(.ELEMS(ELEMS), .LEN_W(LEN_W)) i_len (
        .vec_len (vec_len),
        .open    (len_open)
    );

    // Select the enable source for this prefix.
    always_comb begin
        case (info.kind)
            SRC_ALL: raw_mask = '1;
            SRC_GPR: raw_mask = gpr_bits;
            SRC_CR:  raw_mask = cr_bits;
            default: raw_mask = '0;
        endcase
        next_mask = raw_mask & len_open;
    end

    // Output registers: strobe every cycle, result only on in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_mask    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask    <= next_mask;
                out_illegal <= info.illegal;
            end
        end
    end
endmodule

// File: rtl/pm_mask_checker.sv
// Checker: temporal properties of pred_mask_gen, observed at its ports.
module pm_mask_checker #(
    parameter int ELEMS = 64,
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      prefix,
    input logic [LEN_W-1:0] vec_len,
    input logic             out_valid,
    input logic [ELEMS-1:0] out_mask,
    input logic             out_illegal
);
    logic qual;
    logic [3:0] sel;
    assign qual = (prefix[31:26] == 6'd1) && prefix[24] && prefix[22];
    assign sel  = {prefix[25], prefix[23], prefix[21], prefix[20]};

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("strobe"); // R10

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("strobe width"); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mask) && $stable(out_illegal)) else $error("hold"); // R10

    AST_NONVEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !qual) |=> (out_mask == '0) && !out_illegal) else $error("nonvec"); // R1

    AST_RESERVED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && qual && sel == 4'b0000) |=> out_illegal && (out_mask == '0)) else $error("reserved"); // R3

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_mask >> $past(vec_len)) == '0)) else $error("length"); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !out_valid && (out_mask == '0) && !out_illegal) else $error("reset"); // R11
endmodule

bind pred_mask_gen pm_mask_checker #(.ELEMS(ELEMS), .LEN_W(LEN_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .prefix      (prefix),
    .vec_len     (vec_len),
    .out_valid   (out_valid),
    .out_mask    (out_mask),
    .out_illegal (out_illegal)
);

// File: tb/test_pred_mask_gen.sv
`timescale 1ns/1ps
module test_pred_mask_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  prefix = '0;
    logic [63:0]  gpr_a = '0, gpr_b = '0, gpr_c = '0;
    logic [255:0] cr_file = '0;
    logic [6:0]   vec_len = '0;
    logic         out_valid;
    logic [63:0]  out_mask;
    logic         out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pred_mask_gen i_pred_mask_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prefix(prefix),
        .gpr_a(gpr_a), .gpr_b(gpr_b), .gpr_c(gpr_c), .cr_file(cr_file),
        .vec_len(vec_len), .out_valid(out_valid), .out_mask(out_mask),
        .out_illegal(out_illegal)
    );

    // Reference model from the requirements: returns {illegal, mask}.
    function automatic logic [64:0] model(input logic [31:0] p, input logic [63:0] a,
        input logic [63:0] b, input logic [63:0] c, input logic [255:0] cr, input logic [6:0] len);
        logic [3:0] s;
        logic [63:0] m;
        logic [3:0] f;
        int k;
        s = {p[25], p[23], p[21], p[20]};
        m = '0;
        if (!(p[31:26] == 6'd1 && p[24] && p[22])) return {1'b0, 64'd0};   // R1
        if (s == 4'b0000) return {1'b1, 64'd0};                            // R3
        for (int i = 0; i < 64; i++) begin
            if (i < int'(len)) begin                                        // R9
                case (s[3:1])
                    3'b000: m[i] = 1'b1;                                    // R4
                    3'b001: m[i] = a[i] ^ s[0];                             // R5 R6
                    3'b010: m[i] = b[i] ^ s[0];
                    3'b011: m[i] = c[i] ^ s[0];
                    default: begin                                          // R7 R8
                        k = (6 + i) % 64;
                        f = cr[4*k +: 4];
                        m[i] = f[3 - int'(s[2:1])] ^ s[0];
                    end
                endcase
            end
        end
        return {1'b0, m};
    endfunction

    function automatic logic [31:0] mkpfx(input logic [3:0] s, input logic [31:0] rest);
        logic [31:0] p;
        p = rest;
        p[31:26] = 6'd1; p[24] = 1'b1; p[22] = 1'b1;
        p[25] = s[3]; p[23] = s[2]; p[21] = s[1]; p[20] = s[0];
        return p;
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one vector, sample one edge later, then check the idle hold.
    task automatic apply(input string req, input logic [31:0] p, input logic [6:0] len);
        logic [64:0] exp;
        @(negedge clk);
        prefix = p; vec_len = len; in_valid = 1'b1;
        exp = model(p, gpr_a, gpr_b, gpr_c, cr_file, len);
        @(negedge clk);
        in_valid = 1'b0;
        prefix = $urandom;
        check({req, " R10 strobe"}, {64'd0, out_valid}, 65'd1);
        check(req, {out_illegal, out_mask}, exp);
    endtask

    task automatic randomize_regs();
        gpr_a = {$urandom, $urandom}; gpr_b = {$urandom, $urandom}; gpr_c = {$urandom, $urandom};
        for (int w = 0; w < 8; w++) cr_file[32*w +: 32] = $urandom;
    endtask

    initial begin
        logic [64:0] held;
        void'($urandom(32'd2024));
        // R11: reset with garbage inputs keeps outputs clear
        in_valid = 1'b1; prefix = mkpfx(4'b0001, '0); vec_len = 7'd64;
        repeat (3) @(negedge clk);
        check("R11 reset", {out_valid, out_illegal, out_mask[62:0]}, '0);
        check("R11 reset mask", {1'b0, out_mask}, '0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        randomize_regs();
        apply("R3 reserved", mkpfx(4'b0000, $urandom), 7'd64);
        apply("R4 all len64", mkpfx(4'b0001, $urandom), 7'd64);
        check("R4 all ones", {1'b0, out_mask}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
        apply("R9 len0", mkpfx(4'b0001, $urandom), 7'd0);
        apply("R9 len37", mkpfx(4'b0001, $urandom), 7'd37);
        check("R9 len37 exact", {1'b0, out_mask}, {1'b0, 64'h0000_001F_FFFF_FFFF});
        for (int s = 2; s < 8; s++) apply(s[0] ? "R6 inverted gpr" : "R5 direct gpr", mkpfx(4'(s), $urandom), 7'd64);
        for (int s = 8; s < 16; s++) apply("R7 cr flag", mkpfx(4'(s), $urandom), 7'd64);

        // R8: only field 0 has LT set; element 58 must light alone
        cr_file = '0; cr_file[3] = 1'b1;
        apply("R8 wrap", mkpfx(4'b1000, '0), 7'd64);
        check("R8 element58", {1'b0, out_mask}, {1'b0, 64'd1 << 58});
        // R7: field 6 SO only, SO direct selector -> element 0
        cr_file = '0; cr_file[24] = 1'b1;
        apply("R7 SO order", mkpfx(4'b1110, '0), 7'd64);
        check("R7 element0", {1'b0, out_mask}, 65'd1);

        // R1: each qualification bit broken
        randomize_regs();
        apply("R1 opcode", mkpfx(4'b0001, '0) ^ 32'h0400_0000, 7'd64);
        apply("R1 bit7", mkpfx(4'b0001, '0) & ~32'h0100_0000, 7'd64);
        apply("R1 bit9", mkpfx(4'b0001, '0) & ~32'h0040_0000, 7'd64);
        // R2: other bits don't matter
        apply("R2 rest ones", mkpfx(4'b0100, 32'hFFFF_FFFF), 7'd64);
        apply("R2 rest zero", mkpfx(4'b0100, 32'h0), 7'd64);

        // R10: hold while idle
        held = {out_illegal, out_mask};
        repeat (3) @(negedge clk);
        check("R10 hold", {out_illegal, out_mask}, held);
        check("R10 no strobe", {64'd0, out_valid}, 65'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] p;
            randomize_regs();
            p = ($urandom_range(0, 9) != 0) ? mkpfx(4'($urandom), $urandom) : $urandom;
            apply("R5 R7 R9 random", p, 7'($urandom_range(0, 64)));
        end

        // R11: reset mid-run clears
        apply("R4 before reset", mkpfx(4'b0001, '0), 7'd64);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 midrun", {out_illegal, out_mask}, '0);
        check("R11 midrun strobe", {64'd0, out_valid}, 65'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule